// File: doc/BRIEF.md
# I2C Master Chunk Transfer Engine

This block is an I2C bus master that moves a run of bytes between the bus and a small local byte store in one go. Per-byte interrupts are not needed. Software first fills the store with 32-bit word writes and programs a control word. That word holds the transmit length, the receive length and the store position to begin at. Software then writes a command byte. The engine performs the requested phases in a fixed order: START, transmit, receive, STOP. It raises a one-cycle completion strobe when the command finishes. After completion, software reads the control word back to learn how many bytes were received, or where a transmit was refused.

When a command carries the start phase with the transmit-store enable, the first stored byte is sent as the 8-bit address with the direction bit. The data bytes follow it. A message longer than the store is split across several commands. A command without STOP leaves SCL held low, so the next command continues the same transfer. With both store enables clear, the engine moves a single byte through a byte register instead.

Top module: `i2c_chunk_master`

## Requirements
- R1: After reset the engine is idle: busy, done, tx_nak, scl_oe and sda_oe are all 0, and the control read-back is 0.
- R2: Command bits: bit0 START, bit1 transmit, bit3 receive, bit4 NACK-final-byte, bit5 STOP, bit6 transmit-from-store, bit7 receive-to-store. A command is accepted only while idle, and a command written while busy is ignored. The phases run in the order START, transmit, receive, STOP.
- R3: Control word: bits [31:24] give the received count (read-only), [23:16] the receive length minus one, [15:8] the transmit length minus one, and [5:0] the store start offset. Bits [7:6] read 0.
- R4: With transmit-from-store, the engine sends (transmit field + 1) bytes from the store, MSB first, beginning at the offset. When START is also set, the first of these is the address byte. The byte register is not used.
- R5: With receive-to-store, the engine receives (receive field + 1) bytes into the store from the offset. Every byte is ACKed, except that the final byte is NACKed when bit4 is set. At completion the received-count field equals the number of bytes stored.
- R6: The store position advances by one per byte and wraps modulo the store depth.
- R7: A NACK on any transmitted byte ends transmission and skips the receive phase, while STOP still runs if requested. It sets tx_nak, which stays set until the next accepted command. In store mode it sets the transmit field to the index of the refused byte (bytes sent minus one).
- R8: busy is 1 from the cycle after acceptance through the done cycle. done is high for exactly one cycle per accepted command.
- R9: With the store enables clear, transmit sends the single byte last written to the byte register, and receive delivers one byte on dat_rdata.
- R10: A store word write places bits [8b+7:8b] at byte position 4*word+b.
- R11: During data bits SDA changes only while SCL is low. START drops SDA while SCL is high, and STOP raises SDA while SCL is high. A command without STOP ends with SCL held low.
- R12: Consecutive receive commands without START continue one transfer: the bytes of the second command follow those of the first on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 8 | Command byte |
| ctl_we | input | 1 | Control word write strobe (idle only) |
| ctl_wdata | input | 32 | Control word |
| ctl_rdata | output | 32 | Control word read-back with received count |
| dat_we | input | 1 | Byte register write strobe |
| dat_wdata | input | 8 | Byte to transmit in byte mode |
| dat_rdata | output | 8 | Byte received in byte mode |
| buf_we | input | 1 | Store word write strobe |
| buf_waddr | input | log2(BUF_BYTES)-2 | Store word index |
| buf_wdata | input | 32 | Store word, byte 0 in bits [7:0] |
| buf_raddr | input | log2(BUF_BYTES) | Store byte read index |
| buf_rdata | output | 8 | Store byte read data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| tx_nak | output | 1 | Transmitted byte was refused |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| sda_i | input | 1 | Sensed SDA level |

## Verification
busy is due on the first rising edge after the edge that samples the command write. The bench reads it at the falling edge that follows. The edge that raises done is the same edge that updates tx_nak and the count fields. The bench polls at falling edges until done is seen and reads these results in that half-cycle. One falling edge later, it confirms that done has dropped. Bus traffic is judged by a slave model that reacts only at falling clock edges, and the store and byte read ports are read half a cycle after their index is set.

// File: rtl/i2c_chunk_master.sv
module i2c_chunk_master #(
  parameter int BUF_BYTES = 16,
  parameter int DIV = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_we,
  input  logic [7:0]                   cmd_wdata,
  input  logic                         ctl_we,
  input  logic [31:0]                  ctl_wdata,
  output logic [31:0]                  ctl_rdata,
  input  logic                         dat_we,
  input  logic [7:0]                   dat_wdata,
  output logic [7:0]                   dat_rdata,
  input  logic                         buf_we,
  input  logic [$clog2(BUF_BYTES)-3:0] buf_waddr,
  input  logic [31:0]                  buf_wdata,
  input  logic [$clog2(BUF_BYTES)-1:0] buf_raddr,
  output logic [7:0]                   buf_rdata,
  output logic                         busy,
  output logic                         done,
  output logic                         tx_nak,
  output logic                         scl_oe,
  output logic                         sda_oe,
  input  logic                         sda_i
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int TW = $clog2(DIV + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_TX, S_RX, S_STOP, S_DONE} st_t;

  st_t st;
  logic [7:0] mem [BUF_BYTES];
  logic [7:0] cmd_q, rxc_f, rxs_f, txc_f, txleft, rxleft, txidx, shreg, dat_tx, dat_rx;
  logic [5:0] off_f;
  logic [AW-1:0] ptr;
  logic [1:0] ph;
  logic [3:0] bitn;
  logic [TW-1:0] tick;
  logic scl_q, sda_q, nak_q;
  logic unused_bits;

  function automatic st_t pick(input logic s, input logic t, input logic r,
                               input logic p, input logic [2:0] from);
    if (from <= 3'd1 && s) return S_START;
    if (from <= 3'd2 && t) return S_TX;
    if (from <= 3'd3 && r) return S_RX;
    if (from <= 3'd4 && p) return S_STOP;
    return S_DONE;
  endfunction

  wire step = (st == S_START || st == S_TX || st == S_RX || st == S_STOP)
              && tick == TW'(DIV - 1);
  wire [7:0] txbyte = cmd_q[6] ? mem[ptr] : dat_tx;
  wire accept = cmd_we && st == S_IDLE
                && (cmd_wdata[0] | cmd_wdata[1] | cmd_wdata[3] | cmd_wdata[5]);
  wire rx_store = step && st == S_RX && ph == 2'd3 && bitn == 4'd8 && cmd_q[7];

  assign ctl_rdata = {rxc_f, rxs_f, txc_f, 2'b00, off_f};
  assign dat_rdata = dat_rx;
  assign buf_rdata = mem[buf_raddr];
  assign busy = st != S_IDLE;
  assign done = st == S_DONE;
  assign tx_nak = nak_q;
  assign scl_oe = scl_q;
  assign sda_oe = sda_q;
  assign unused_bits = ^{ctl_wdata[31:24], ctl_wdata[7:6]};

  always_ff @(posedge clk) begin
    if (rx_store) mem[ptr] <= shreg;
    else if (buf_we)
      for (int b = 0; b < 4; b++) mem[{buf_waddr, 2'(b)}] <= buf_wdata[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cmd_q <= '0; rxc_f <= '0; rxs_f <= '0; txc_f <= '0; off_f <= '0;
      txleft <= '0; rxleft <= '0; txidx <= '0; shreg <= '0;
      dat_tx <= '0; dat_rx <= '0; ptr <= '0; ph <= '0; bitn <= '0; tick <= '0;
      scl_q <= 1'b0; sda_q <= 1'b0; nak_q <= 1'b0;
    end else if (st == S_IDLE) begin
      if (ctl_we) begin
        rxs_f <= ctl_wdata[23:16];
        txc_f <= ctl_wdata[15:8];
        off_f <= ctl_wdata[5:0];
        ptr   <= ctl_wdata[AW-1:0];
      end
      if (dat_we) dat_tx <= dat_wdata;
      if (accept) begin
        cmd_q  <= cmd_wdata;
        st     <= pick(cmd_wdata[0], cmd_wdata[1], cmd_wdata[3], cmd_wdata[5], 3'd1);
        ph     <= '0;
        bitn   <= '0;
        tick   <= '0;
        nak_q  <= 1'b0;
        txidx  <= '0;
        txleft <= cmd_wdata[6] ? txc_f : 8'd0;
        rxleft <= cmd_wdata[7] ? rxs_f : 8'd0;
        if (cmd_wdata[7]) rxc_f <= '0;
      end
    end else if (st == S_DONE) begin
      st  <= S_IDLE;
      ptr <= off_f[AW-1:0];
    end else begin
      tick <= step ? '0 : tick + 1'b1;
      if (step) begin
        ph <= ph + 1'b1;
        case (st)
          S_START:
            case (ph)
              2'd0: sda_q <= 1'b0;
              2'd1: scl_q <= 1'b0;
              2'd2: sda_q <= 1'b1;
              default: begin
                scl_q <= 1'b1;
                bitn  <= '0;
                st    <= pick(cmd_q[0], cmd_q[1], cmd_q[3], cmd_q[5], 3'd2);
              end
            endcase
          S_TX:
            case (ph)
              2'd0: sda_q <= (bitn < 4'd8) ? ~txbyte[3'(4'd7 - bitn)] : 1'b0;
              2'd1: scl_q <= 1'b0;
              2'd2: ;
              default: begin
                scl_q <= 1'b1;
                if (bitn != 4'd8) bitn <= bitn + 1'b1;
                else begin
                  bitn <= '0;
                  if (cmd_q[6]) ptr <= ptr + 1'b1;
                  if (sda_i) begin
                    nak_q <= 1'b1;
                    if (cmd_q[6]) txc_f <= txidx;
                    st <= pick(cmd_q[0], cmd_q[1], cmd_q[3], cmd_q[5], 3'd4);
                  end else if (txleft == 8'd0)
                    st <= pick(cmd_q[0], cmd_q[1], cmd_q[3], cmd_q[5], 3'd3);
                  else begin
                    txleft <= txleft - 1'b1;
                    txidx  <= txidx + 1'b1;
                  end
                end
              end
            endcase
          S_RX:
            case (ph)
              2'd0: sda_q <= (bitn == 4'd8) ? !(rxleft == 8'd0 && cmd_q[4]) : 1'b0;
              2'd1: scl_q <= 1'b0;
              2'd2: ;
              default: begin
                scl_q <= 1'b1;
                if (bitn != 4'd8) begin
                  shreg <= {shreg[6:0], sda_i};
                  bitn  <= bitn + 1'b1;
                end else begin
                  bitn <= '0;
                  if (!cmd_q[7]) dat_rx <= shreg;
                  else begin
                    rxc_f <= rxc_f + 8'd1;
                    ptr   <= ptr + 1'b1;
                  end
                  if (rxleft == 8'd0)
                    st <= pick(cmd_q[0], cmd_q[1], cmd_q[3], cmd_q[5], 3'd4);
                  else rxleft <= rxleft - 1'b1;
                end
              end
            endcase
          S_STOP:
            case (ph)
              2'd0: sda_q <= 1'b1;
              2'd1: scl_q <= 1'b0;
              2'd2: sda_q <= 1'b0;
              default: st <= S_DONE;
            endcase
          default: ;
        endcase
      end
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_NAK_FROM_TX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nak_q) |-> $past(st) == S_TX); // R7
  AST_RXCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_q[7]) |-> ({1'b0, rxc_f} <= {1'b0, rxs_f} + 9'd1)); // R5
  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_TX || st == S_RX) && $past(st) == st && !scl_q && !$past(scl_q))
    |-> $stable(sda_q)); // R11
endmodule

// File: tb/sim_i2c_chunk_master.sv
module sim_i2c_chunk_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 0, ctl_we = 0, dat_we = 0, buf_we = 0;
  logic [7:0] cmd_wdata = 0, dat_wdata = 0;
  logic [31:0] ctl_wdata = 0, buf_wdata = 0;
  logic [1:0] buf_waddr = 0;
  logic [3:0] buf_raddr = 0;
  logic [31:0] ctl_rdata;
  logic [7:0] dat_rdata, buf_rdata;
  logic busy, done, tx_nak, scl_oe, sda_oe;
  bit pull = 0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || pull);

  always #2 clk = ~clk;

  i2c_chunk_master #(.BUF_BYTES(16), .DIV(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata), .busy(busy), .done(done),
    .tx_nak(tx_nak), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_line));

  // slave bus model: reacts at falling clock edges only
  int bitc = -2, bytec = 0, txi = 0, rx_n = 0, mack_n = 0, starts = 0, stops = 0;
  int nak_idx = -1;
  bit stx = 0, sdone = 0, dir = 0, pscl = 1, psda = 1;
  logic [7:0] inb = 0, tbyte;
  logic [7:0] rx_log [64];
  bit mack_log [64];
  int done_cnt = 0;

  always @(posedge clk) if (done) done_cnt++;

  always @(negedge clk) begin
    if (scl_line && pscl) begin
      if (psda && !sda_line) begin
        starts++; bitc = -1; bytec = 0; stx = 0; sdone = 0; dir = 0; pull = 0;
      end else if (!psda && sda_line) begin
        stops++; bitc = -2; stx = 0; pull = 0;
      end
    end else if (scl_line && !pscl && bitc >= 0) begin
      if (!stx && bitc < 8) inb = {inb[6:0], sda_line};
      if (stx && !sdone && bitc == 8) begin
        mack_log[mack_n & 63] = !sda_line; mack_n++; txi++;
        if (sda_line) sdone = 1;
      end
    end else if (!scl_line && pscl && bitc >= -1) begin
      if (bitc == -1) bitc = 0;
      else begin
        bitc = (bitc == 8) ? 0 : bitc + 1;
        if (!stx) begin
          if (bitc == 8) begin
            rx_log[rx_n & 63] = inb; rx_n++;
            pull = (nak_idx != bytec);
            if (bytec == 0) dir = inb[0];
            bytec++;
          end else if (bitc == 0 && dir && bytec == 1) begin
            stx = 1; txi = 0; tbyte = 8'hA0; pull = !tbyte[7];
          end else pull = 0;
        end else if (sdone || bitc == 8) pull = 0;
        else begin
          tbyte = 8'hA0 + 8'(txi);
          pull = !tbyte[7 - bitc];
        end
      end
    end
    psda = sda_line; pscl = scl_line;
  end

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input int act, input int exp, input string tag);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask
  task automatic wr_cmd(input logic [7:0] c);
    @(negedge clk); cmd_we = 1; cmd_wdata = c;
    @(negedge clk); cmd_we = 0;
  endtask
  task automatic wr_ctl(input logic [31:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask
  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); dat_we = 1; dat_wdata = v;
    @(negedge clk); dat_we = 0;
  endtask
  task automatic wr_buf(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk); buf_we = 1; buf_waddr = a; buf_wdata = v;
    @(negedge clk); buf_we = 0;
  endtask
  task automatic rd_buf(input int idx, output logic [7:0] v);
    buf_raddr = 4'(idx); #1; v = buf_rdata;
  endtask
  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    if (!done) chk(0, 1, {tag, " done timeout"});
  endtask

  // fields: tx length-1, offset, NACK byte index (FF = none)
  localparam logic [23:0] VEC [5] = '{24'h03_00_FF, 24'h05_04_02, 24'h03_0E_FF,
                                       24'h02_08_00, 24'h00_02_FF};

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    int base, sbase, mbase, dbase, errs, acks;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({busy, done, tx_nak, scl_oe, sda_oe}, 0, "R1 outputs after reset");
    chk(ctl_rdata, 0, "R1 control read-back after reset");

    wr_ctl(32'hFF05_07EA);
    @(negedge clk);
    chk(ctl_rdata, 32'h0005_072A, "R3 control field read-back");

    for (int v = 0; v < 5; v++) begin
      logic [7:0] tm1, off, nk;
      int sent, expnak, exptx;
      tm1 = VEC[v][23:16]; off = VEC[v][15:8]; nk = VEC[v][7:0];
      for (int w = 0; w < 4; w++) begin
        logic [31:0] word;
        for (int k = 0; k < 4; k++)
          word[8*k +: 8] = (4*w + k == int'(off)) ? 8'h84 : 8'h40 + 8'(4*w + k);
        wr_buf(2'(w), word);
      end
      if (nk != 8'hFF && nk <= tm1) begin
        sent = nk + 1; expnak = 1; exptx = nk; nak_idx = nk;
      end else begin
        sent = tm1 + 1; expnak = 0; exptx = tm1; nak_idx = -1;
      end
      wr_ctl({16'h0000, tm1, 2'b00, off[5:0]});
      base = rx_n; sbase = stops;
      wr_cmd(8'h63);
      chk(busy, 1, "R8 busy after accept");
      wait_done("R4");
      chk(tx_nak, expnak, "R7 refusal flag");
      chk(ctl_rdata[15:8], exptx, "R7/R4 transmit field after chunk");
      chk(rx_n - base, sent, "R4 bytes on bus");
      errs = 0;
      for (int k = 0; k < sent; k++) begin
        int j;
        j = (int'(off) + k) % 16;
        if (rx_log[(base + k) & 63] != ((k == 0) ? 8'h84 : 8'h40 + 8'(j))) errs++;
      end
      chk(errs, 0, "R4/R6/R10 byte values and order");
      chk(stops - sbase, 1, "R11 stop after chunk");
      chk(scl_oe, 0, "R11 clock released after stop");
      @(negedge clk);
      chk(done, 0, "R8 done lasts one cycle");
    end

    // command written while busy is ignored
    nak_idx = -1;
    wr_buf(0, 32'h4342_4184);
    wr_ctl(32'h0000_0300);
    base = rx_n; dbase = done_cnt;
    wr_cmd(8'h63);
    repeat (10) @(negedge clk);
    wr_cmd(8'h23);
    wait_done("R2");
    repeat (400) @(negedge clk);
    chk(done_cnt - dbase, 1, "R2 one completion, busy write ignored");
    chk(rx_n - base, 4, "R2 only first command on bus");

    // read address, then two receive chunks
    wr_buf(0, 32'h0000_0085);
    wr_ctl(32'h0000_0000);
    sbase = stops;
    wr_cmd(8'h43);
    wait_done("R11");
    chk(scl_oe, 1, "R11 clock held low without stop");
    wr_ctl(32'h0003_0000);
    mbase = mack_n;
    wr_cmd(8'h88);
    wait_done("R5");
    chk(ctl_rdata[31:24], 4, "R5 received count chunk 1");
    errs = 0;
    for (int k = 0; k < 4; k++) begin rd_buf(k, b); if (b != 8'hA0 + 8'(k)) errs++; end
    chk(errs, 0, "R5 stored bytes chunk 1");
    acks = 0;
    for (int k = 0; k < 4; k++) if (mack_log[(mbase + k) & 63]) acks++;
    chk(acks, 4, "R5 all bytes acked without final-NACK bit");
    wr_ctl(32'h0002_0008);
    mbase = mack_n;
    wr_cmd(8'hB8);
    wait_done("R12");
    chk(ctl_rdata[31:24], 3, "R5 received count chunk 2");
    errs = 0;
    for (int k = 0; k < 3; k++) begin rd_buf(8 + k, b); if (b != 8'hA4 + 8'(k)) errs++; end
    chk(errs, 0, "R12 second chunk continues the byte stream");
    chk({mack_log[mbase & 63], mack_log[(mbase + 1) & 63], mack_log[(mbase + 2) & 63]},
        3'b110, "R5 final byte NACKed");
    chk(stops - sbase, 1, "R11 single stop over the split read");

    // byte mode
    wr_dat(8'h85);
    wr_cmd(8'h03);
    wait_done("R9");
    mbase = mack_n;
    wr_cmd(8'h38);
    wait_done("R9");
    chk(dat_rdata, 8'hA0, "R9 byte-mode receive");
    chk(mack_log[mbase & 63], 0, "R9 byte-mode final NACK");
    wr_dat(8'h84);
    base = rx_n;
    wr_cmd(8'h23);
    wait_done("R9");
    chk(rx_n - base, 1, "R9 byte-mode transmit count");
    chk(rx_log[base & 63], 8'h84, "R9 byte-mode transmit value");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule